// File: doc/BRIEF.md
# DDR SDRAM Bank-State Protocol Guard

This block is a passive observer placed on the command bus between a DDR SDRAM controller and its device. On every rising clock edge it decodes the command from the select, row strobe, column strobe and write strobe lines, all active low. It also samples the clock enable, the two-bit bank field and the auto-precharge/all-banks bit. It never drives the bus. It follows each of the four banks through its own set of states: closed, opening, open, read or write burst (with or without auto-precharge), write recovery, and closing. It also tracks a device-wide quiet window after a refresh or a mode-register load.

When a command breaks the rules for the state it reaches, the block pulses `err_valid` for one cycle and reports a cause code on `err_code`. All timing windows are parameters counted in clock cycles. A burst lasts `BURST_LEN/2` cycles. A rejected command changes no tracked state, while every timer keeps counting.

Top module: `ddr_bank_guard`

## Requirements
- R1: The command is decoded from {sel_n, row_n, col_n, wr_n}. sel_n high is deselect. L,H,H,H is no-op. L,L,H,H opens a row. L,L,H,L closes (precharge). L,H,L,H is read. L,H,L,L is write. L,L,L,H is refresh (entry to self-refresh if clk_en is low). L,H,H,L stops a burst. L,L,L,L loads the mode register. A deselect or a no-op never raises an error.
- R2: A violation sampled at edge n gives err_valid=1 between edge n and edge n+1, for one cycle per offending command. err_code is 1 for a wrong bank state, 2 for a bank not idle, 3 inside a refresh or mode window, and 4 for a forbidden burst stop. Priority is 3, then 2, then 4/1. err_valid=0 and err_code=0 otherwise, and after reset.
- R3: In a closed bank, read and write give code 1 and a burst stop gives code 4. A precharge there is harmless. Opening a row is legal.
- R4: After a row opens at cycle n, any open, close, read or write to that bank in cycles n+1..n+T_RCD-1 gives code 1. A read at n+T_RCD is legal.
- R5: A precharge at n with ap_bit low closes the bank named by bank_addr. With ap_bit high it closes every bank, and bank_addr is ignored. Such a command is rejected whole if any bank forbids it. In cycles n+1..n+T_RP-1, read, write and open give code 1, and another precharge is harmless. The bank is closed and idle at n+T_RP.
- R6: A read at n without auto-precharge holds a burst for cycles n+1..n+BURST_LEN/2-1. In that burst, a burst stop is legal and returns the bank to open, a new read restarts the burst, and a write gives code 1. A burst stop to an open, idle-burst bank is harmless.
- R7: A write at n without auto-precharge holds a burst for n+1..n+BURST_LEN/2-1, in which a read or write may interrupt it and a burst stop gives code 4. The burst is followed by T_WR recovery cycles. In those cycles read, write, open and close give code 1 and a burst stop gives code 4.
- R8: A read or write with ap_bit high forbids read, write, open and close to that bank during its burst (code 1) and a burst stop (code 4). The bank then precharges by itself: a read at n is idle at n+BURST_LEN/2+T_RP, and a write at n is idle at n+BURST_LEN/2+T_WR+T_RP.
- R9: A refresh or mode load while any bank is not closed and idle gives code 2.
- R10: After an accepted refresh at n, every command other than no-op or deselect in n+1..n+T_RFC-1 gives code 3. After a mode load the window is n+1..n+T_MRD-1.
- R11: Rules apply only when clk_en was high at the previous edge and at the current one. Otherwise the command is ignored: it raises no error and changes no state. This includes self-refresh entry.
- R12: Banks are tracked independently, and a rejected command leaves every bank's state unchanged.
- R13: Opening a row in a bank that is already open gives code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip select, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| clk_en | input | 1 | Device clock enable |
| bank_addr | input | BANK_W (2) | Bank selected by the command |
| ap_bit | input | 1 | Auto-precharge on read/write, all banks on precharge |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Violation cause, 0 when no violation |

## Verification
The bench drives the bus through several distinct patterns:
- Read bursts that are restarted, stopped and crossed by writes, which separate the plain-read rules from the plain-write rules.
- Write bursts followed into recovery.
- Auto-precharge reads and writes probed in every phase up to the exact cycle the bank becomes usable again, which shows whether each countdown has the right length.
- All-bank precharges, both refused and accepted, together with refresh and mode loads issued too early and exactly on time. These expose the priority between cause codes.
- Cycles with clock enable low, followed by a command that would be illegal, which show whether ignored commands leave state alone.

A behavioural timestamp model in the bench predicts every cycle's pulse, and hand-computed codes pin down the key cases.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_IDLE,
        CMD_OPEN_ROW,
        CMD_CLOSE,
        CMD_READ,
        CMD_WRITE,
        CMD_REFRESH,
        CMD_SELF_REF,
        CMD_STOP,
        CMD_LOAD_MODE
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        B_IDLE,
        B_OPENING,
        B_OPEN,
        B_RD,
        B_RD_AP,
        B_WR,
        B_WR_AP,
        B_WREC,
        B_WREC_AP,
        B_CLOSING
    } bank_st_e;

    localparam logic [3:0] ERR_NONE     = 4'd0;
    localparam logic [3:0] ERR_BANK     = 4'd1;
    localparam logic [3:0] ERR_NOT_IDLE = 4'd2;
    localparam logic [3:0] ERR_WINDOW   = 4'd3;
    localparam logic [3:0] ERR_STOP     = 4'd4;

endpackage

// File: rtl/ddr_guard_decode.sv
module ddr_guard_decode
    import ddr_guard_pkg::*;
(
    input  logic     sel_n,
    input  logic     row_n,
    input  logic     col_n,
    input  logic     wr_n,
    input  logic     clk_en,
    output ddr_cmd_e cmd
);
    always_comb begin
        if (sel_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({row_n, col_n, wr_n})
                3'b111:  cmd = CMD_IDLE;
                3'b011:  cmd = CMD_OPEN_ROW;
                3'b010:  cmd = CMD_CLOSE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b001:  cmd = clk_en ? CMD_REFRESH : CMD_SELF_REF;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_LOAD_MODE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_guard_bank.sv
module ddr_guard_bank
    import ddr_guard_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int BANK_W    = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int BURST_CYC = 2,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ddr_cmd_e          cmd,
    input  logic [BANK_W-1:0] bank_addr,
    input  logic              ap_bit,
    input  logic              apply_i,
    output logic              illegal_o,
    output logic              idle_o
);
    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bstate_t;

    bstate_t r_d, r_q;
    logic    hit;

    // State reached when a timed phase runs out; the new phase gets its full length.
    function automatic bstate_t follow(bank_st_e s);
        bstate_t f;
        f.st  = s;
        f.cnt = '0;
        case (s)
            B_OPENING, B_RD, B_WREC: f.st = B_OPEN;
            B_RD_AP, B_WREC_AP: begin f.st = B_CLOSING; f.cnt = CNT_W'(T_RP); end
            B_WR:               begin f.st = B_WREC;    f.cnt = CNT_W'(T_WR); end
            B_WR_AP:            begin f.st = B_WREC_AP; f.cnt = CNT_W'(T_WR); end
            B_CLOSING:          f.st = B_IDLE;
            default:            f.st = s;
        endcase
        return f;
    endfunction

    // Phase started by a command at cycle n covers n+1 .. n+len-1.
    function automatic bstate_t start(bank_st_e s, int len);
        bstate_t f;
        if (len > 1) begin
            f.st  = s;
            f.cnt = CNT_W'(len - 1);
        end else begin
            f = follow(s);
        end
        return f;
    endfunction

    function automatic logic forbidden(bank_st_e s, ddr_cmd_e c);
        logic bank_cmd;
        bank_cmd = (c == CMD_OPEN_ROW) || (c == CMD_CLOSE) || (c == CMD_READ) ||
                   (c == CMD_WRITE) || (c == CMD_STOP);
        case (s)
            B_IDLE:    return (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_STOP);
            B_OPEN:    return (c == CMD_OPEN_ROW);
            B_RD:      return (c == CMD_OPEN_ROW) || (c == CMD_WRITE);
            B_WR:      return (c == CMD_OPEN_ROW) || (c == CMD_STOP);
            B_CLOSING: return bank_cmd && (c != CMD_CLOSE);
            default:   return bank_cmd;
        endcase
    endfunction

    always_comb begin
        hit = ((cmd == CMD_CLOSE) && ap_bit) ||
              ((bank_addr == BANK_W'(IDX)) &&
               ((cmd == CMD_OPEN_ROW) || (cmd == CMD_CLOSE) || (cmd == CMD_READ) ||
                (cmd == CMD_WRITE) || (cmd == CMD_STOP)));
        illegal_o = hit && forbidden(r_q.st, cmd);
        idle_o    = (r_q.st == B_IDLE);

        r_d = r_q;
        if ((r_q.st != B_IDLE) && (r_q.st != B_OPEN)) begin
            if (r_q.cnt <= CNT_W'(1)) r_d = follow(r_q.st);
            else                      r_d.cnt = r_q.cnt - 1'b1;
        end

        if (hit && apply_i) begin
            case (cmd)
                CMD_OPEN_ROW: r_d = start(B_OPENING, T_RCD);
                CMD_READ:     r_d = start(ap_bit ? B_RD_AP : B_RD, BURST_CYC);
                CMD_WRITE:    r_d = start(ap_bit ? B_WR_AP : B_WR, BURST_CYC);
                CMD_CLOSE: begin
                    if ((r_q.st != B_IDLE) && (r_q.st != B_CLOSING))
                        r_d = start(B_CLOSING, T_RP);
                end
                CMD_STOP: begin
                    if (r_q.st == B_RD) begin
                        r_d.st  = B_OPEN;
                        r_d.cnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= B_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int T_RFC     = 10,
    parameter int T_MRD     = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              row_n,
    input  logic              col_n,
    input  logic              wr_n,
    input  logic              clk_en,
    input  logic [BANK_W-1:0] bank_addr,
    input  logic              ap_bit,
    output logic              err_valid,
    output logic [3:0]        err_code
);
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int CNT_W     = $clog2(T_RFC + T_RCD + T_RP + T_WR + T_MRD + BURST_CYC + 2);

    typedef struct packed {
        logic             cke;
        logic [CNT_W-1:0] win;
        logic             err;
        logic [3:0]       code;
    } top_t;

    top_t                 d, q;
    ddr_cmd_e             cmd_raw, cmd_eff;
    logic [NUM_BANKS-1:0] ill_vec, idle_vec;
    logic                 apply, win_busy, real_cmd;
    logic [3:0]           code;

    ddr_guard_decode u_dec (
        .sel_n (sel_n),
        .row_n (row_n),
        .col_n (col_n),
        .wr_n  (wr_n),
        .clk_en(clk_en),
        .cmd   (cmd_raw)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        ddr_guard_bank #(
            .IDX      (gi),
            .BANK_W   (BANK_W),
            .T_RCD    (T_RCD),
            .T_RP     (T_RP),
            .T_WR     (T_WR),
            .BURST_CYC(BURST_CYC),
            .CNT_W    (CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_eff),
            .bank_addr(bank_addr),
            .ap_bit   (ap_bit),
            .apply_i  (apply),
            .illegal_o(ill_vec[gi]),
            .idle_o   (idle_vec[gi])
        );
    end

    always_comb begin
        cmd_eff  = (q.cke && clk_en) ? cmd_raw : CMD_IDLE;
        real_cmd = (cmd_eff != CMD_IDLE) && (cmd_eff != CMD_DESEL);
        win_busy = (q.win != '0);

        code = ERR_NONE;
        if (win_busy && real_cmd)
            code = ERR_WINDOW;
        else if (((cmd_eff == CMD_REFRESH) || (cmd_eff == CMD_LOAD_MODE)) && !(&idle_vec))
            code = ERR_NOT_IDLE;
        else if (|ill_vec)
            code = (cmd_eff == CMD_STOP) ? ERR_STOP : ERR_BANK;
        apply = (code == ERR_NONE);

        d      = q;
        d.cke  = clk_en;
        d.err  = (code != ERR_NONE);
        d.code = code;
        if (win_busy)
            d.win = q.win - 1'b1;
        else if (apply && (cmd_eff == CMD_REFRESH))
            d.win = CNT_W'(T_RFC > 0 ? T_RFC - 1 : 0);
        else if (apply && (cmd_eff == CMD_LOAD_MODE))
            d.win = CNT_W'(T_MRD > 0 ? T_MRD - 1 : 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cke  <= 1'b1;
            q.win  <= '0;
            q.err  <= 1'b0;
            q.code <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign err_valid = q.err;
    assign err_code  = q.code;
endmodule

// File: rtl/ddr_bank_guard_chk.sv
module ddr_bank_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n,
    input logic       row_n,
    input logic       col_n,
    input logic       wr_n,
    input logic       clk_en,
    input logic       err_valid,
    input logic [3:0] err_code
);
    AST_QUIET_ON_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || (row_n && col_n && wr_n)) |=> !err_valid); // R1

    AST_QUIET_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !err_valid); // R11

    AST_NOT_IDLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 4'd2) |-> $past(!sel_n && !row_n && !col_n)); // R9

    AST_STOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 4'd4) |-> $past(!sel_n && row_n && col_n && !wr_n)); // R2

    AST_BANK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 4'd1) |-> $past(!sel_n && (row_n != col_n))); // R2

    AST_CODE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_valid) |-> (err_code == 4'd0 || err_valid)); // R2
endmodule

bind ddr_bank_guard ddr_bank_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .row_n    (row_n),
    .col_n    (col_n),
    .wr_n     (wr_n),
    .clk_en   (clk_en),
    .err_valid(err_valid),
    .err_code (err_code)
);

// File: tb/tb_ddr_bank_guard.sv
module tb_ddr_bank_guard;
    localparam int TRCD = 3, TRP = 3, TWR = 2, TRFC = 10, TMRD = 2, BC = 2;
    localparam int K_DES = 0, K_NOP = 1, K_OPEN = 2, K_CLOSE = 3, K_RD = 4, K_WR = 5,
                   K_REF = 6, K_STOP = 7, K_MODE = 8, K_SREF = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b0, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1, clk_en = 1'b1, ap_bit = 1'b0;
    logic [1:0] bank_addr = 2'd0;
    logic       err_valid;
    logic [3:0] err_code;

    int checks = 0, errors = 0;
    int t = 0;
    int m_cke_prev = 1, win_end = 0;
    int rowopen[4], ready_at[4], bend[4], rend[4], idle_at[4], bkind[4], bap[4];

    always #10 clk = ~clk;

    ddr_bank_guard dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n),
        .wr_n(wr_n), .clk_en(clk_en), .bank_addr(bank_addr), .ap_bit(ap_bit),
        .err_valid(err_valid), .err_code(err_code)
    );

    // 0 closed, 1 opening, 2 open, 3 read, 4 write, 5 read+ap, 6 write+ap, 7 recovery, 8 closing
    function automatic int mstate(int b, int tc);
        if (rowopen[b] == 0) return (tc < idle_at[b]) ? 8 : 0;
        if (tc < ready_at[b]) return 1;
        if (bkind[b] == 1 && tc < bend[b]) return bap[b] ? 5 : 3;
        if (bkind[b] == 2 && tc < bend[b]) return bap[b] ? 6 : 4;
        if (bkind[b] == 2 && tc < rend[b]) return 7;
        if (bap[b] != 0) return (tc < idle_at[b]) ? 8 : 0;
        return 2;
    endfunction

    function automatic bit mforbid(int s, int k);
        bit bk;
        bk = (k == K_OPEN || k == K_CLOSE || k == K_RD || k == K_WR || k == K_STOP);
        case (s)
            0: return (k == K_RD || k == K_WR || k == K_STOP);
            2: return (k == K_OPEN);
            3: return (k == K_OPEN || k == K_WR);
            4: return (k == K_OPEN || k == K_STOP);
            8: return bk && (k != K_CLOSE);
            default: return bk;
        endcase
    endfunction

    function automatic int model_step();
        int k, code;
        bit all_idle, any_bad, gate, tgt;
        if (sel_n) k = K_DES;
        else case ({row_n, col_n, wr_n})
            3'b111: k = K_NOP;
            3'b011: k = K_OPEN;
            3'b010: k = K_CLOSE;
            3'b101: k = K_RD;
            3'b100: k = K_WR;
            3'b001: k = clk_en ? K_REF : K_SREF;
            3'b110: k = K_STOP;
            default: k = K_MODE;
        endcase
        gate = (m_cke_prev != 0) && clk_en;
        m_cke_prev = clk_en ? 1 : 0;
        if (!gate) k = K_NOP;
        all_idle = 1'b1;
        any_bad  = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (mstate(i, t) != 0) all_idle = 1'b0;
            tgt = (k == K_CLOSE && ap_bit) || (i == int'(bank_addr));
            if (tgt && mforbid(mstate(i, t), k)) any_bad = 1'b1;
        end
        code = 0;
        if (k != K_NOP && k != K_DES && t < win_end) code = 3;
        else if ((k == K_REF || k == K_MODE) && !all_idle) code = 2;
        else if (any_bad) code = (k == K_STOP) ? 4 : 1;
        if (code == 0) begin
            if (k == K_REF)  win_end = t + TRFC;
            if (k == K_MODE) win_end = t + TMRD;
            for (int i = 0; i < 4; i++) begin
                tgt = (k == K_CLOSE && ap_bit) || (i == int'(bank_addr));
                if (tgt) begin
                    int s;
                    s = mstate(i, t);
                    case (k)
                        K_OPEN: begin rowopen[i] = 1; ready_at[i] = t + TRCD; bkind[i] = 0; bap[i] = 0; end
                        K_RD: begin
                            bkind[i] = 1; bap[i] = ap_bit; bend[i] = t + BC;
                            if (ap_bit) idle_at[i] = t + BC + TRP;
                        end
                        K_WR: begin
                            bkind[i] = 2; bap[i] = ap_bit; bend[i] = t + BC; rend[i] = t + BC + TWR;
                            if (ap_bit) idle_at[i] = t + BC + TWR + TRP;
                        end
                        K_CLOSE: if (s != 0 && s != 8) begin
                            rowopen[i] = 0; bkind[i] = 0; bap[i] = 0; idle_at[i] = t + TRP;
                        end
                        K_STOP: if (s == 3) bkind[i] = 0;
                        default: ;
                    endcase
                end
            end
        end
        t++;
        return code;
    endfunction

    task automatic step(input logic [3:0] pins, input logic ck, input int b, input logic ap,
                        input string req, input int hand);
        int exp;
        {sel_n, row_n, col_n, wr_n} = pins;
        clk_en = ck; bank_addr = 2'(b); ap_bit = ap;
        @(posedge clk);
        exp = model_step();
        @(negedge clk);
        checks++;
        if (err_valid !== (exp != 0) || int'(err_code) != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual valid=%0b code=%0d expected code=%0d",
                     req, t - 1, err_valid, err_code, exp);
        end
        if (hand >= 0) begin
            checks++;
            if (int'(err_code) != hand || err_valid !== (hand != 0)) begin
                errors++;
                $display("FAIL %s cycle %0d: actual code=%0d expected code=%0d",
                         req, t - 1, err_code, hand);
            end
        end
    endtask

    task automatic nop(input string req, input int h);      step(4'b0111, 1'b1, 0, 1'b0, req, h); endtask
    task automatic opn(input int b, input string req, input int h); step(4'b0011, 1'b1, b, 1'b0, req, h); endtask
    task automatic cls(input int b, input logic all, input string req, input int h); step(4'b0010, 1'b1, b, all, req, h); endtask
    task automatic rd(input int b, input logic ap, input string req, input int h); step(4'b0101, 1'b1, b, ap, req, h); endtask
    task automatic wr(input int b, input logic ap, input string req, input int h); step(4'b0100, 1'b1, b, ap, req, h); endtask
    task automatic stp(input int b, input string req, input int h); step(4'b0110, 1'b1, b, 1'b0, req, h); endtask
    task automatic rfs(input string req, input int h);      step(4'b0001, 1'b1, 0, 1'b0, req, h); endtask
    task automatic mode(input string req, input int h);     step(4'b0000, 1'b1, 0, 1'b0, req, h); endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            rowopen[i] = 0; ready_at[i] = 0; bend[i] = 0; rend[i] = 0;
            idle_at[i] = 0; bkind[i] = 0; bap[i] = 0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (err_valid !== 1'b0 || err_code !== 4'd0) begin
            errors++;
            $display("FAIL R2 reset: actual valid=%0b code=%0d expected valid=0 code=0", err_valid, err_code);
        end
        rst_n = 1'b1;

        mode("R9", 0);
        opn(0, "R10", 3);            // inside mode window
        opn(0, "R3", 0);
        rd(0, 0, "R4", 1);           // still opening
        nop("R1", 0);
        rd(0, 0, "R4", 0);           // exactly T_RCD later
        wr(0, 0, "R6", 1);           // write inside plain read burst
        rd(0, 0, "R6", 0);
        stp(0, "R6", 0);             // stop ends read burst
        stp(0, "R6", 0);             // stop on open bank is harmless
        rd(0, 0, "R6", 0);
        rd(0, 0, "R6", 0);           // restart inside burst
        nop("R1", 0);
        wr(0, 0, "R7", 0);
        stp(0, "R7", 4);             // stop inside write burst
        rd(0, 0, "R7", 1);           // recovery
        cls(0, 0, "R7", 1);          // recovery
        wr(0, 0, "R7", 0);
        rd(0, 0, "R7", 0);           // read interrupts write
        nop("R1", 0);
        opn(0, "R13", 1);
        rd(0, 1, "R8", 0);           // read with auto-precharge
        rd(0, 0, "R8", 1);
        opn(0, "R8", 1);             // closing
        nop("R1", 0);
        cls(0, 0, "R5", 0);          // precharge while closing is harmless
        opn(0, "R8", 0);             // idle exactly BC+T_RP later
        stp(1, "R3", 4);
        rd(1, 0, "R3", 1);
        wr(0, 1, "R8", 0);           // write with auto-precharge
        stp(0, "R8", 4);
        opn(0, "R8", 1);             // recovery
        nop("R1", 0);
        rd(0, 0, "R8", 1);           // closing
        cls(1, 0, "R3", 0);          // precharge on idle bank
        nop("R1", 0);
        opn(0, "R8", 0);             // idle at BC+T_WR+T_RP
        opn(1, "R12", 0);
        cls(3, 1, "R5", 1);          // all-bank precharge refused
        rd(0, 0, "R12", 0);          // bank 0 untouched by refusal
        rfs("R9", 2);
        mode("R9", 2);
        cls(3, 1, "R5", 0);          // all-bank precharge, bank field ignored
        opn(0, "R5", 1);
        cls(1, 0, "R5", 0);
        rfs("R9", 0);
        opn(2, "R10", 3);
        for (int i = 0; i < 8; i++) nop("R10", 0);
        opn(2, "R10", 0);            // exactly T_RFC later
        nop("R1", 0);
        nop("R1", 0);
        step(4'b0101, 1'b0, 1, 1'b0, "R11", 0);   // read to idle bank, clk_en low
        step(4'b0101, 1'b1, 1, 1'b0, "R11", 0);   // previous clk_en low
        rd(1, 0, "R11", 1);                       // checked again, bank still idle
        step(4'b0001, 1'b0, 0, 1'b0, "R11", 0);   // self-refresh entry ignored
        nop("R11", 0);
        rd(2, 0, "R12", 0);
        mode("R9", 2);
        nop("R1", 0);
        summary();
    end
endmodule